// File: doc/BRIEF.md
# Interrupt Source Event-State Array

This block holds a two-bit event state for each of `NSRC` interrupt sources and changes that state through a small address-decoded access port. The data carried by an access does nothing. Three things select the operation: the access direction (load or store), whether the access hits the source's trigger page or its management page, and the top four bits of the offset inside the page. The two state bits are named P and Q. P means a notification is outstanding. Q means a further event arrived while P was set. The combination P=0, Q=1 means the source is switched off.

An event can come from a store to the trigger page or from a per-source hardware pulse. Each event either raises a one-cycle notification toward the downstream event queue or is folded into the state. Loads at two special management offsets return the state as it was and then write a fixed new state. Software uses these loads to mask and unmask a source, so no separate mask register exists. An end-of-interrupt access clears P. If Q was set, it re-notifies at once, so no coalesced event is lost.

Top module: `esb_pq_array`

## Requirements
- R1: After reset every source holds state 01 (masked), `notify` is all zero and `rd_vld` is low.
- R2: An event applies this state change to its source: 00 goes to 10 and pulses that source's `notify` bit; 10 goes to 11; 11 stays 11; 01 stays 01 and the event is dropped. A store to the trigger page (`acc_trig_page`=1, any offset, any data) is such an event.
- R3: A high `hw_trig[i]` in a cycle is an event for source i alone, with the same effect as in R2. The sources act independently of one another.
- R4: A management-page load whose offset top nibble is 0xC (offset 0xC00) returns the old state and sets the state to 00.
- R5: A management-page load whose offset top nibble is 0xD (offset 0xD00) returns the old state and sets the state to 01.
- R6: A management-page store whose offset top nibble is 0x4 (offset 0x400) is an end of interrupt. It changes 11 to 10 and pulses `notify`, and changes 10 to 00. It leaves 00 and 01 unchanged.
- R7: A management-page load whose offset top nibble is 0x0 returns the old state and makes the same state change as R6, including the notification.
- R8: Any other load (other management nibbles, or any load on the trigger page) returns the state and leaves it unchanged. Management-page stores at nibbles other than 0x4 have no effect. Offset bits below the top nibble are ignored.
- R9: If a port access and `hw_trig` hit the same source in the same cycle, the port operation is applied first and the event second. `notify` is the OR of both steps.
- R10: Each load gives `rd_vld`=1 on the next cycle, with `rd_pq` holding the state from before the access: P in bit 1 (0x2) and Q in bit 0 (0x1). `rd_vld` is 0 after any cycle without a load. `notify` pulses on the cycle after the operation that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Access present this cycle |
| acc_we | input | 1 | 1 = store, 0 = load |
| acc_src | input | SRC_W | Source index of the access |
| acc_trig_page | input | 1 | 1 = trigger page, 0 = management page |
| acc_off | input | OFF_W | Offset within the page; only the top nibble is decoded |
| acc_wdata | input | DATA_W | Store data, ignored |
| hw_trig | input | NSRC | Per-source hardware event pulses |
| rd_vld | output | 1 | Load result valid |
| rd_pq | output | 2 | State before the load, P in bit 1, Q in bit 0 |
| notify | output | NSRC | One-cycle notification per source |

## Verification
Directed sequences take one source through all four states, using trigger-page stores, hardware pulses and both forms of end of interrupt. These sequences separate the coalescing path (10 to 11) from the notifying path (00 to 10) and from the masked path, where the event is dropped. Offsets with random low bits and stores at the mask offsets check that only the nibble and the direction decide the operation. A same-cycle end of interrupt plus hardware pulse shows the order of the two steps. A long random mix of accesses and sparse pulse vectors, compared every cycle against a reference model, catches interference between sources and wrong read-back values.

// File: rtl/esb_pq_pkg.sv
package esb_pq_pkg;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_TRIG,
      OP_EOI,
      OP_SET00,
      OP_SET01,
      OP_QUERY
   } esb_op_e;

   localparam logic [1:0] PQ_IDLE   = 2'b00;
   localparam logic [1:0] PQ_OFF    = 2'b01;
   localparam logic [1:0] PQ_PEND   = 2'b10;
   localparam logic [1:0] PQ_QUEUED = 2'b11;

   // returns {notify, next_state}
   function automatic logic [2:0] event_step(input logic [1:0] pq);
      case (pq)
         PQ_IDLE:   return {1'b1, PQ_PEND};
         PQ_PEND:   return {1'b0, PQ_QUEUED};
         PQ_QUEUED: return {1'b0, PQ_QUEUED};
         default:   return {1'b0, PQ_OFF};
      endcase
   endfunction

   function automatic logic [2:0] eoi_step(input logic [1:0] pq);
      case (pq)
         PQ_QUEUED: return {1'b1, PQ_PEND};
         PQ_PEND:   return {1'b0, PQ_IDLE};
         default:   return {1'b0, pq};
      endcase
   endfunction

endpackage

// File: rtl/esb_op_decode.sv
module esb_op_decode
   import esb_pq_pkg::*;
#(
   parameter int OFF_W = 12
) (
   input  logic             vld,
   input  logic             we,
   input  logic             trig_page,
   input  logic [OFF_W-1:0] off,
   output esb_op_e          op
);
   localparam int NIB_LSB = OFF_W - 4;

   initial begin
      if (OFF_W < 4) $error("OFF_W must be at least 4");
   end

   logic [3:0] nib;
   assign nib = off[NIB_LSB +: 4];

   generate
      if (NIB_LSB > 0) begin : g_low
         logic unused_low;
         assign unused_low = ^off[NIB_LSB-1:0];
      end
   endgenerate

   always_comb begin
      op = OP_NONE;
      if (vld) begin
         if (trig_page) begin
            op = we ? OP_TRIG : OP_QUERY;
         end else if (we) begin
            op = (nib == 4'h4) ? OP_EOI : OP_NONE;
         end else begin
            case (nib)
               4'h0:    op = OP_EOI;
               4'hC:    op = OP_SET00;
               4'hD:    op = OP_SET01;
               default: op = OP_QUERY;
            endcase
         end
      end
   end
endmodule

// File: rtl/esb_cell.sv
module esb_cell
   import esb_pq_pkg::*;
#(
   parameter bit RST_MASKED = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  esb_op_e    op,
   input  logic       hw_evt,
   output logic [1:0] pq,
   output logic       notify
);
   logic [1:0] rst_val;

   generate
      if (RST_MASKED) begin : g_rst_off
         assign rst_val = PQ_OFF;
      end else begin : g_rst_idle
         assign rst_val = PQ_IDLE;
      end
   endgenerate

   logic [1:0] mid_pq, nxt_pq;
   logic       bus_ntf, evt_ntf;
   logic [2:0] bus_res, evt_res;

   always_comb begin
      case (op)
         OP_TRIG:  bus_res = event_step(pq);
         OP_EOI:   bus_res = eoi_step(pq);
         OP_SET00: bus_res = {1'b0, PQ_IDLE};
         OP_SET01: bus_res = {1'b0, PQ_OFF};
         default:  bus_res = {1'b0, pq};
      endcase
      bus_ntf = bus_res[2];
      mid_pq  = bus_res[1:0];
      evt_res = hw_evt ? event_step(mid_pq) : {1'b0, mid_pq};
      evt_ntf = evt_res[2];
      nxt_pq  = evt_res[1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pq     <= rst_val;
         notify <= 1'b0;
      end else begin
         pq     <= nxt_pq;
         notify <= bus_ntf | evt_ntf;
      end
   end
endmodule

// File: rtl/esb_pq_array.sv
module esb_pq_array
   import esb_pq_pkg::*;
#(
   parameter int NSRC       = 8,
   parameter int SRC_W      = (NSRC > 1) ? $clog2(NSRC) : 1,
   parameter int OFF_W      = 12,
   parameter int DATA_W     = 64,
   parameter bit RST_MASKED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_vld,
   input  logic              acc_we,
   input  logic [SRC_W-1:0]  acc_src,
   input  logic              acc_trig_page,
   input  logic [OFF_W-1:0]  acc_off,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic [NSRC-1:0]   hw_trig,
   output logic              rd_vld,
   output logic [1:0]        rd_pq,
   output logic [NSRC-1:0]   notify
);
   localparam int FULL_MAP = (NSRC == (1 << SRC_W)) ? 1 : 0;

   initial begin
      if (NSRC < 1) $error("NSRC must be at least 1");
      if ((1 << SRC_W) < NSRC) $error("SRC_W too narrow for NSRC");
      if (DATA_W < 1) $error("DATA_W must be at least 1");
   end

   logic unused_data;
   assign unused_data = ^acc_wdata;

   esb_op_e op;

   esb_op_decode #(.OFF_W(OFF_W)) u_dec (
      .vld       (acc_vld),
      .we        (acc_we),
      .trig_page (acc_trig_page),
      .off       (acc_off),
      .op        (op)
   );

   logic [NSRC-1:0][1:0] pq_q;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      esb_op_e cell_op;
      assign cell_op = (acc_src == SRC_W'(i)) ? op : OP_NONE;
      esb_cell #(.RST_MASKED(RST_MASKED)) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .op     (cell_op),
         .hw_evt (hw_trig[i]),
         .pq     (pq_q[i]),
         .notify (notify[i])
      );
   end

   logic [1:0] sel_pq;
   generate
      if (FULL_MAP == 1) begin : g_full
         assign sel_pq = pq_q[acc_src];
      end else begin : g_part
         assign sel_pq = (acc_src < SRC_W'(NSRC)) ? pq_q[acc_src] : 2'b00;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_vld <= 1'b0;
         rd_pq  <= 2'b00;
      end else begin
         rd_vld <= acc_vld & ~acc_we;
         if (acc_vld && !acc_we) rd_pq <= sel_pq;
      end
   end
endmodule

// File: rtl/esb_pq_chk.sv
module esb_pq_chk #(
   parameter int NSRC  = 8,
   parameter int SRC_W = 3,
   parameter int OFF_W = 12
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 acc_vld,
   input logic                 acc_we,
   input logic [SRC_W-1:0]     acc_src,
   input logic                 acc_trig_page,
   input logic [OFF_W-1:0]     acc_off,
   input logic [NSRC-1:0]      hw_trig,
   input logic                 rd_vld,
   input logic [NSRC-1:0]      notify,
   input logic [NSRC-1:0][1:0] pq
);
   localparam int NIB_LSB = OFF_W - 4;

   logic [3:0] nib;
   assign nib = acc_off[NIB_LSB +: 4];
   logic mgmt_ld;
   assign mgmt_ld = acc_vld && !acc_we && !acc_trig_page;

   a_r10_rd_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && !acc_we) |=> rd_vld);

   a_r10_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_vld && !acc_we) |=> !rd_vld);

   for (genvar i = 0; i < NSRC; i++) begin : g_chk
      a_r4_unmask: assert property (@(posedge clk) disable iff (!rst_n)
         (mgmt_ld && nib == 4'hC && acc_src == SRC_W'(i) && !hw_trig[i])
         |=> pq[i] == 2'b00);

      a_r5_mask: assert property (@(posedge clk) disable iff (!rst_n)
         (mgmt_ld && nib == 4'hD && acc_src == SRC_W'(i) && !hw_trig[i])
         |=> pq[i] == 2'b01);

      a_r2_drop: assert property (@(posedge clk) disable iff (!rst_n)
         (pq[i] == 2'b01 && !(acc_vld && acc_src == SRC_W'(i)))
         |=> !notify[i]);

      a_r2_notify_p: assert property (@(posedge clk) disable iff (!rst_n)
         notify[i] |-> pq[i][1]);
   end
endmodule

bind esb_pq_array esb_pq_chk #(.NSRC(NSRC), .SRC_W(SRC_W), .OFF_W(OFF_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .acc_vld       (acc_vld),
   .acc_we        (acc_we),
   .acc_src       (acc_src),
   .acc_trig_page (acc_trig_page),
   .acc_off       (acc_off),
   .hw_trig       (hw_trig),
   .rd_vld        (rd_vld),
   .notify        (notify),
   .pq            (pq_q)
);

// File: tb/esb_pq_array_tb.sv
module esb_pq_array_tb;
   localparam int NSRC   = 8;
   localparam int SRC_W  = 3;
   localparam int OFF_W  = 12;
   localparam int DATA_W = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              acc_vld = 1'b0;
   logic              acc_we = 1'b0;
   logic [SRC_W-1:0]  acc_src = '0;
   logic              acc_trig_page = 1'b0;
   logic [OFF_W-1:0]  acc_off = '0;
   logic [DATA_W-1:0] acc_wdata = '0;
   logic [NSRC-1:0]   hw_trig = '0;
   logic              rd_vld;
   logic [1:0]        rd_pq;
   logic [NSRC-1:0]   notify;

   int checks = 0;
   int errors = 0;
   logic [1:0] m [NSRC];

   always #10 clk = ~clk;

   esb_pq_array #(.NSRC(NSRC), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_we(acc_we),
      .acc_src(acc_src), .acc_trig_page(acc_trig_page), .acc_off(acc_off),
      .acc_wdata(acc_wdata), .hw_trig(hw_trig), .rd_vld(rd_vld),
      .rd_pq(rd_pq), .notify(notify));

   function automatic logic [2:0] ref_evt(input logic [1:0] s);
      if (s == 2'b00) return 3'b110;
      if (s == 2'b10) return 3'b011;
      if (s == 2'b11) return 3'b011;
      return 3'b001;
   endfunction

   function automatic logic [2:0] ref_eoi(input logic [1:0] s);
      if (s == 2'b11) return 3'b110;
      if (s == 2'b10) return 3'b000;
      return {1'b0, s};
   endfunction

   // bus effect on one source: {notify, state}
   function automatic logic [2:0] ref_bus(input logic we, input logic tp,
                                           input logic [3:0] nib, input logic [1:0] s);
      if (tp) return we ? ref_evt(s) : {1'b0, s};
      if (we) return (nib == 4'h4) ? ref_eoi(s) : {1'b0, s};
      if (nib == 4'h0) return ref_eoi(s);
      if (nib == 4'hC) return 3'b000;
      if (nib == 4'hD) return 3'b001;
      return {1'b0, s};
   endfunction

   task automatic check(input string tag, input logic ok, input logic [15:0] act,
                        input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic vld, input logic we, input int src, input logic tp,
                       input logic [OFF_W-1:0] off, input logic [NSRC-1:0] hw,
                       input string tag);
      logic [NSRC-1:0] exp_n;
      logic [1:0] exp_rd;
      logic [2:0] r;
      acc_vld = vld; acc_we = we; acc_src = SRC_W'(src); acc_trig_page = tp;
      acc_off = off; acc_wdata = {$urandom, $urandom}; hw_trig = hw;
      exp_rd = m[src];
      for (int i = 0; i < NSRC; i++) begin
         r = {1'b0, m[i]};
         if (vld && i == src) r = ref_bus(we, tp, off[OFF_W-1 -: 4], m[i]);
         if (hw[i]) begin
            logic n0;
            n0 = r[2];
            r = ref_evt(r[1:0]);
            r[2] = r[2] | n0;
         end
         exp_n[i] = r[2];
         m[i] = r[1:0];
      end
      @(negedge clk);
      check({tag, " rd_vld"}, rd_vld == (vld && !we), 16'(rd_vld), 16'(vld && !we));
      if (vld && !we) check({tag, " rd_pq"}, rd_pq == exp_rd, 16'(rd_pq), 16'(exp_rd));
      check({tag, " notify"}, notify == exp_n, 16'(notify), 16'(exp_n));
   endtask

   task automatic idle();
      acc_vld = 1'b0; hw_trig = '0;
      @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < NSRC; i++) m[i] = 2'b01;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1 rd_vld", rd_vld == 1'b0, 16'(rd_vld), 16'd0);
      check("R1 notify", notify == '0, 16'(notify), 16'd0);
      for (int i = 0; i < NSRC; i++) step(1, 0, i, 0, 12'h800, '0, "R1 R8 query");
      // R4 unmask, R2 trigger-page events
      step(1, 0, 2, 0, 12'hC00, '0, "R4 unmask");
      step(1, 0, 2, 0, 12'h8AA, '0, "R4 query");
      step(1, 1, 2, 1, 12'h123, '0, "R2 00to10");
      step(1, 1, 2, 1, 12'h000, '0, "R2 10to11");
      step(1, 1, 2, 1, 12'hFFF, '0, "R2 11stay");
      // R6 store EOI
      step(1, 1, 2, 0, 12'h400, '0, "R6 11to10");
      step(1, 1, 2, 0, 12'h400, '0, "R6 10to00");
      step(1, 1, 2, 0, 12'h400, '0, "R6 00stay");
      // R3 hardware event, R7 load EOI
      step(0, 0, 0, 0, 12'h000, 8'h04, "R3 hw");
      step(1, 0, 2, 0, 12'h000, '0, "R7 load eoi");
      step(1, 0, 2, 1, 12'h000, '0, "R8 trig page load");
      // R5 mask then dropped events
      step(1, 0, 2, 0, 12'hD00, '0, "R5 mask");
      step(1, 1, 2, 1, 12'h000, '0, "R2 masked drop");
      step(0, 0, 0, 0, 12'h000, 8'h04, "R3 masked drop");
      step(1, 1, 2, 0, 12'h400, '0, "R6 masked eoi");
      step(1, 0, 2, 0, 12'h800, '0, "R5 still masked");
      // R8 low offset bits ignored, store at mask offset ignored
      step(1, 0, 2, 0, 12'hC7F, '0, "R8 low bits");
      step(1, 1, 2, 0, 12'hD00, '0, "R8 store ignored");
      step(1, 0, 2, 0, 12'h900, '0, "R8 state kept");
      // R9 same-cycle EOI and hardware event on source 3
      step(1, 0, 3, 0, 12'hC00, '0, "R9 prep");
      step(0, 0, 0, 0, 12'h000, 8'h08, "R9 prep pend");
      step(1, 1, 3, 0, 12'h400, 8'h08, "R9 eoi then event");
      step(1, 0, 3, 0, 12'h800, '0, "R9 result");
      // R10 idle gives no read
      idle();
      check("R10 idle", rd_vld == 1'b0, 16'(rd_vld), 16'd0);
      // random mix
      for (int k = 0; k < 4000; k++) begin
         logic [3:0] nibs [6];
         logic [NSRC-1:0] hw;
         logic [OFF_W-1:0] off;
         nibs[0] = 4'h0; nibs[1] = 4'h4; nibs[2] = 4'hC;
         nibs[3] = 4'hD; nibs[4] = 4'h8; nibs[5] = 4'h4;
         off = {nibs[$urandom % 6], 8'($urandom)};
         hw = '0;
         for (int i = 0; i < NSRC; i++) hw[i] = ($urandom % 6) == 0;
         step(($urandom % 5) != 0, $urandom % 2, $urandom % NSRC,
              ($urandom % 4) == 0, off, hw, "R10 random");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
   end
endmodule